// File: doc/BRIEF.md
# Disk interface status capture register

This block is the read-only status byte of a floppy controller's host interface. It watches the disk-side signals the controller drives and receives: write pulses, read pulses, write enable, two motor-on lines, four active-low drive selects and the active-low "second drive present" input. It also watches the drive-select-0 bit of the controller's output register. From these it builds an 8-bit value that the host can read at any time on `status_o`.

Two byte layouts can be selected with `layout_sel`. The toggle layout (0) shows a constant `11` pattern, a copy of the output register's drive-select-0 bit, two bits that flip on each write-pulse or read-pulse edge, and the live write-enable and motor levels. The latch layout (1) shows the raw active-low select and second-drive levels, and three sticky bits. Each sticky bit is set by a signal edge and cleared by a read strobe from a separate input register.

Every disk signal passes through a two-flop synchronizer. Edges are found on the synchronized copies. The hardware reset `rst` clears all state. The software reset `soft_rst` clears only the edge-derived bits.

Top module: `disk_status_capture`

## Requirements
- R1: While `rst` is high, `status_o` loads 8'hC0 in the toggle layout and 8'hE3 in the latch layout. The layout is taken from `layout_sel` during reset.
- R2: In the toggle layout (`layout_sel`=0), bits 7 and 6 of `status_o` always read 1.
- R3: In the toggle layout, bit 5 follows `out_reg_sel0_i` two clock edges later. `rst` clears it. `soft_rst` does not change it.
- R4: In the toggle layout, bit 4 inverts once for each falling edge of `wr_pulse_i`.
- R5: In the toggle layout, bit 3 inverts once for each rising edge of `rd_pulse_i`.
- R6: In the toggle layout, bit 2 is the `wr_enable_i` level, bit 1 is `motor_on_i[1]` and bit 0 is `motor_on_i[0]`.
- R7: In the latch layout, bit 7 is `second_drive_n_i`, bit 6 is `sel_n_i[1]`, bit 5 is `sel_n_i[0]`, bit 1 is `sel_n_i[3]` and bit 0 is `sel_n_i[2]`.
- R8: In the latch layout, bit 4 is set by a falling edge of `wr_pulse_i`, whatever the level of `wr_enable_i`.
- R9: In the latch layout, bit 3 is set by a falling edge of `rd_pulse_i`.
- R10: In the latch layout, bit 2 is set by a rising edge of `wr_enable_i`.
- R11: A one-cycle pulse on `in_reg_read_i` clears the three sticky bits. If a setting edge is detected in the same cycle, that bit stays set.
- R12: `soft_rst` clears the two toggle bits and the three sticky bits.
- R13: Timing from a disk input change to `status_o`: a level bit shows the new value after the third rising edge. An edge-derived bit shows the change after the fourth rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| soft_rst | input | 1 | Synchronous software reset, active high |
| layout_sel | input | 1 | 0 = toggle layout, 1 = latch layout |
| wr_pulse_i | input | 1 | Write data pulse line, active high |
| rd_pulse_i | input | 1 | Read data pulse line, active high |
| wr_enable_i | input | 1 | Write enable line, active high |
| motor_on_i | input | 2 | Motor-on levels for drives 1 and 0 |
| sel_n_i | input | 4 | Active-low drive select lines for drives 3..0 |
| second_drive_n_i | input | 1 | Second drive present, active low |
| out_reg_sel0_i | input | 1 | Drive-select-0 bit of the output register |
| in_reg_read_i | input | 1 | Read strobe of the input register, one cycle |
| status_o | output | 8 | Registered status byte |

## Verification
The hardest case is a clear strobe that arrives in exactly the cycle in which a new edge is detected. The edge is only seen two edges after the pin changes, so the strobe cannot be lined up by looking at the pins. The bench drives a falling write pulse and counts two rising edges. It then raises the read strobe for the third edge and checks that the sticky bit survives. Long random runs add more of these collisions. The behavioural model compares every cycle, in both layouts, including around software resets.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef struct packed {
    logic       drive2_n;
    logic [3:0] sel_n;
    logic [1:0] motor;
    logic       gate;
    logic       rdat;
    logic       wdat;
  } disk_sig_t;

  localparam int SIG_W = $bits(disk_sig_t);

  localparam disk_sig_t SIG_IDLE = '{drive2_n: 1'b1, sel_n: 4'hF, motor: 2'b00,
                                      gate: 1'b0, rdat: 1'b0, wdat: 1'b0};

  typedef enum logic {LAYOUT_TOGGLE = 1'b0, LAYOUT_LATCH = 1'b1} layout_e;

  localparam logic [7:0] TOGGLE_RST_VAL = 8'hC0;
  localparam logic [7:0] LATCH_RST_VAL  = 8'hE3;

endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dsc_toggle.sv
module dsc_toggle #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wipe_i,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] flag_o
);
  always_ff @(posedge clk) begin
    if (rst || wipe_i) flag_o <= '0;
    else               flag_o <= flag_o ^ evt_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_chk
    // R4 R5
    toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(evt_i[g]) && !$past(wipe_i) && !$past(rst)) |-> (flag_o[g] != $past(flag_o[g])));
  end
endmodule

// File: rtl/dsc_sticky.sv
module dsc_sticky #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wipe_i,
  input  logic         clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] flag_o
);
  always_ff @(posedge clk) begin
    if (rst || wipe_i) flag_o <= '0;
    else               flag_o <= set_i | (flag_o & ~{W{clr_i}});
  end

  for (genvar g = 0; g < W; g++) begin : g_chk
    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(set_i[g]) && !$past(wipe_i) && !$past(rst)) |-> flag_o[g]);
    // R11
    clear_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(clr_i) && !$past(set_i[g])) |-> !flag_o[g]);
  end
endmodule

// File: rtl/disk_status_capture.sv
module disk_status_capture
  import dsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       soft_rst,
  input  logic       layout_sel,
  input  logic       wr_pulse_i,
  input  logic       rd_pulse_i,
  input  logic       wr_enable_i,
  input  logic [1:0] motor_on_i,
  input  logic [3:0] sel_n_i,
  input  logic       second_drive_n_i,
  input  logic       out_reg_sel0_i,
  input  logic       in_reg_read_i,
  output logic [7:0] status_o
);
  localparam int N_TOG = 2;
  localparam int N_STK = 3;

  disk_sig_t raw, syn, prv;
  logic [N_TOG-1:0] tog_evt, tog_q;
  logic [N_STK-1:0] stk_evt, stk_q;
  logic             dor0_q;
  logic [7:0]       nxt;
  layout_e          lay;

  assign raw = '{drive2_n: second_drive_n_i, sel_n: sel_n_i, motor: motor_on_i,
                 gate: wr_enable_i, rdat: rd_pulse_i, wdat: wr_pulse_i};
  assign lay = layout_e'(layout_sel);

  dsc_sync #(.W(SIG_W), .STAGES(SYNC_STAGES), .RST_VAL(SIG_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw), .q_o(syn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prv    <= SIG_IDLE;
      dor0_q <= 1'b0;
    end else begin
      prv    <= syn;
      dor0_q <= out_reg_sel0_i;
    end
  end

  // index 0: write pulse falling, 1: read pulse rising
  assign tog_evt = {~prv.rdat & syn.rdat, prv.wdat & ~syn.wdat};
  // index 0: write enable rising, 1: read pulse falling, 2: write pulse falling
  assign stk_evt = {prv.wdat & ~syn.wdat, prv.rdat & ~syn.rdat, ~prv.gate & syn.gate};

  dsc_toggle #(.W(N_TOG)) u_toggle (
    .clk(clk), .rst(rst), .wipe_i(soft_rst), .evt_i(tog_evt), .flag_o(tog_q)
  );

  dsc_sticky #(.W(N_STK)) u_sticky (
    .clk(clk), .rst(rst), .wipe_i(soft_rst), .clr_i(in_reg_read_i),
    .set_i(stk_evt), .flag_o(stk_q)
  );

  always_comb begin
    if (lay == LAYOUT_TOGGLE)
      nxt = {2'b11, dor0_q, tog_q[0], tog_q[1], syn.gate, syn.motor};
    else
      nxt = {syn.drive2_n, syn.sel_n[1], syn.sel_n[0], stk_q[2], stk_q[1], stk_q[0],
             syn.sel_n[3], syn.sel_n[2]};
  end

  always_ff @(posedge clk) begin
    if (rst) status_o <= (lay == LAYOUT_TOGGLE) ? TOGGLE_RST_VAL : LATCH_RST_VAL;
    else     status_o <= nxt;
  end

  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status_o == ($past(layout_sel) ? LATCH_RST_VAL : TOGGLE_RST_VAL)));
  // R2
  fixed_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(layout_sel)) |-> (status_o[7:6] == 2'b11));
  // R3
  sel0_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(layout_sel)) |-> (status_o[5] == $past(out_reg_sel0_i, 2)));
endmodule

// File: tb/test_disk_status_capture.sv
module test_disk_status_capture;
  logic       clk = 1'b0;
  logic       rst = 1'b1, soft_rst = 1'b0, layout_sel = 1'b0;
  logic       wr_pulse_i = 1'b0, rd_pulse_i = 1'b0, wr_enable_i = 1'b0;
  logic [1:0] motor_on_i = 2'b00;
  logic [3:0] sel_n_i = 4'hF;
  logic       second_drive_n_i = 1'b1, out_reg_sel0_i = 1'b0, in_reg_read_i = 1'b0;
  logic [7:0] status_o;

  int checks = 0, errors = 0;
  bit done = 0, started = 0;

  always #4 clk = ~clk;

  disk_status_capture i_disk_status_capture (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .layout_sel(layout_sel),
    .wr_pulse_i(wr_pulse_i), .rd_pulse_i(rd_pulse_i), .wr_enable_i(wr_enable_i),
    .motor_on_i(motor_on_i), .sel_n_i(sel_n_i), .second_drive_n_i(second_drive_n_i),
    .out_reg_sel0_i(out_reg_sel0_i), .in_reg_read_i(in_reg_read_i), .status_o(status_o)
  );

  // Reference model. Input snapshot bits: 9 second drive, 8:5 selects 3..0,
  // 4:3 motors, 2 write enable, 1 read pulse, 0 write pulse.
  logic [9:0] h1 = 10'h3E0, h2 = 10'h3E0, h3 = 10'h3E0;
  bit w_par = 0, r_par = 0, s_w = 0, s_r = 0, s_g = 0, sel0 = 0;
  logic [7:0] exp_st = 8'hC0;

  always @(posedge clk) begin
    logic [7:0] nx;
    bit ew, er_up, er_dn, eg;
    if (rst) begin
      h1 = 10'h3E0; h2 = 10'h3E0; h3 = 10'h3E0;
      w_par = 0; r_par = 0; s_w = 0; s_r = 0; s_g = 0; sel0 = 0;
      exp_st = layout_sel ? 8'hE3 : 8'hC0;
    end else begin
      if (!layout_sel) nx = {2'b11, sel0, w_par, r_par, h2[2], h2[4], h2[3]};
      else             nx = {h2[9], h2[6], h2[5], s_w, s_r, s_g, h2[8], h2[7]};
      ew    = h3[0] && !h2[0];
      er_up = !h3[1] && h2[1];
      er_dn = h3[1] && !h2[1];
      eg    = !h3[2] && h2[2];
      if (soft_rst) begin
        w_par = 0; r_par = 0; s_w = 0; s_r = 0; s_g = 0;
      end else begin
        if (ew) w_par = !w_par;
        if (er_up) r_par = !r_par;
        s_w = ew    || (s_w && !in_reg_read_i);
        s_r = er_dn || (s_r && !in_reg_read_i);
        s_g = eg    || (s_g && !in_reg_read_i);
      end
      sel0 = out_reg_sel0_i;
      exp_st = nx;
      h3 = h2; h2 = h1;
      h1 = {second_drive_n_i, sel_n_i, motor_on_i, wr_enable_i, rd_pulse_i, wr_pulse_i};
    end
    started = 1;
  end

  function automatic string bit_req(int b, bit lay);
    if (!lay) case (b)
      7, 6: return "R2"; 5: return "R3"; 4: return "R4"; 3: return "R5"; default: return "R6";
    endcase
    else case (b)
      4: return "R8"; 3: return "R9"; 2: return "R10"; default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (status_o !== exp_st) begin
        errors++;
        for (int b = 7; b >= 0; b--)
          if (status_o[b] !== exp_st[b]) begin
            $display("FAIL %s model: status=%h expected %h (bit %0d)", bit_req(b, layout_sel),
                     status_o, exp_st, b);
            break;
          end
      end
    end
  end

  task automatic chk(string req, logic [7:0] exp);
    checks++;
    if (status_o !== exp) begin
      errors++;
      $display("FAIL %s: status=%h expected %h", req, status_o, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wr();
    wr_pulse_i = 1; tick(3); wr_pulse_i = 0; tick(3);
  endtask

  task automatic pulse_rd();
    rd_pulse_i = 1; tick(3); rd_pulse_i = 0; tick(3);
  endtask

  initial begin
    #(8ns * 100000);
    errors++; checks++;
    $display("FAIL watchdog: status=%h expected completion", status_o);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3); rst = 0; tick(1);
    chk("R1 toggle reset", 8'hC0);
    out_reg_sel0_i = 1; tick(1);
    chk("R3 two-edge delay", 8'hC0);
    tick(1);
    chk("R3 mirror", 8'hE0);
    soft_rst = 1; tick(1); soft_rst = 0; tick(4);
    chk("R3 survives soft reset", 8'hE0);
    wr_enable_i = 1; motor_on_i = 2'b10; tick(2);
    chk("R13 not before third edge", 8'hE0);
    tick(1);
    chk("R6 R13 levels", 8'hE6);
    wr_enable_i = 0; motor_on_i = 2'b01; tick(4);
    chk("R6 levels", 8'hE1);
    wr_pulse_i = 1; tick(3); wr_pulse_i = 0; tick(3);
    chk("R4 R13 not before fourth edge", 8'hE1);
    tick(1);
    chk("R4 one fall", 8'hF1);
    pulse_rd(); tick(1);
    chk("R5 one rise", 8'hF9);
    pulse_wr(); tick(1);
    chk("R4 two falls", 8'hE9);
    soft_rst = 1; tick(1); soft_rst = 0; tick(4);
    chk("R12 toggles cleared", 8'hE1);
    layout_sel = 1; sel_n_i = 4'b0110; second_drive_n_i = 0; motor_on_i = 0; tick(4);
    chk("R7 direct levels", 8'h41);
    pulse_wr(); tick(1);
    chk("R8 write fall, enable low", 8'h51);
    pulse_rd(); tick(1);
    chk("R9 read fall", 8'h59);
    wr_enable_i = 1; tick(5);
    chk("R10 enable rise", 8'h5D);
    in_reg_read_i = 1; tick(1); in_reg_read_i = 0; tick(2);
    chk("R11 read clears", 8'h41);
    wr_pulse_i = 1; tick(4);
    wr_pulse_i = 0; tick(2);
    in_reg_read_i = 1; tick(1); in_reg_read_i = 0; tick(2);
    chk("R11 set wins over clear", 8'h51);
    soft_rst = 1; tick(1); soft_rst = 0; tick(2);
    chk("R12 sticky cleared", 8'h41);
    rst = 1; tick(2);
    chk("R1 latch reset", 8'hE3);
    layout_sel = 0; tick(1); rst = 0; tick(1);
    chk("R3 cleared by hardware reset", 8'hC0);
    for (int i = 0; i < 3000; i++) begin
      wr_pulse_i = $urandom_range(0, 1); rd_pulse_i = $urandom_range(0, 1);
      wr_enable_i = $urandom_range(0, 1); motor_on_i = 2'($urandom);
      sel_n_i = 4'($urandom); second_drive_n_i = $urandom_range(0, 1);
      out_reg_sel0_i = $urandom_range(0, 1);
      in_reg_read_i = ($urandom_range(0, 3) == 0);
      soft_rst = ($urandom_range(0, 63) == 0);
      if (i % 500 == 0) layout_sel = !layout_sel;
      tick(1);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule